// File: doc/BRIEF.md
# Supply-Aware Memory Access Guard

This block sits between a host and a byte-wide static memory array. It decides, from the state of the supply, whether the array may be accessed. Three comparator results come in as asynchronous flags: the supply is above the upper deselect level, above the lower deselect level, or above the battery switchover level. The host's active-low chip-enable, output-enable and write-enable strobes come in as well. The block produces the gated array select, the gated write strobe, the data-bus drive enable, a write-protect flag and a battery-select flag.

With a healthy supply the strobes are decoded into standby, write, read and output-off modes. When the supply sags, the array is locked out and every strobe is ignored. After the supply returns, the lockout holds for a recovery interval counted on the system clock. A sudden collapse that skips the deselect window is modelled with a configurable lag before the lockout takes hold.

Top module: `supply_access_guard`

## Requirements
- R1: While reset is low and right after it is released, `wprot_o` is 1 and `access_o`, `mem_we_o` and `dq_oe_o` are 0. The synchronised flags read as 0, so `bat_sel_o` is 1.
- R2: Each comparator flag passes through two flip-flops. A flag value sampled at rising edge k reaches `bat_sel_o` after edge k+1 and first affects the protection state at edge k+2.
- R3: The flags are treated as monotonic. A set flag counts only if every lower-level flag is also set, so an inconsistent combination is read as the lowest level that it allows.
- R4: While access is allowed, a synchronised level that is below the upper threshold but above the lower one sets `wprot_o` at the next edge.
- R5: When the synchronised level drops straight from healthy to below the lower threshold, access stays allowed for exactly LAG_CYC cycles and `wprot_o` then sets. LAG_CYC = ceil(LAG_NS/CLK_NS), and a value of 0 means the lockout is immediate.
- R6: `wprot_o` clears only after REC_CYC consecutive cycles at the healthy level while protected. REC_CYC = ceil(REC_NS/CLK_NS). Any non-healthy cycle restarts the count.
- R7: `bat_sel_o` is 1 exactly when the synchronised switchover flag is 0.
- R8: When not protected, the mode table applies. `ce_n_i`=1 gives standby with all three outputs 0. `ce_n_i`=0 with `we_n_i`=0 gives a write: `access_o`=1, `mem_we_o`=1, `dq_oe_o`=0. `ce_n_i`=0, `oe_n_i`=0 and `we_n_i`=1 gives a read: `access_o`=1, `dq_oe_o`=1. `ce_n_i`=0 with `oe_n_i`=1 and `we_n_i`=1 gives `access_o`=1 and `dq_oe_o`=0.
- R9: While `wprot_o` is 1, the strobes have no effect and `access_o`, `mem_we_o` and `dq_oe_o` stay 0.
- R10: A write in progress when protection asserts is cut off in the same cycle that `wprot_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_hi_i | input | 1 | 1 = supply above the upper deselect level (asynchronous) |
| vcc_lo_i | input | 1 | 1 = supply above the lower deselect level (asynchronous) |
| vcc_bat_i | input | 1 | 1 = supply above the battery switchover level (asynchronous) |
| ce_n_i | input | 1 | Host chip enable, active low |
| oe_n_i | input | 1 | Host output enable, active low |
| we_n_i | input | 1 | Host write enable, active low |
| access_o | output | 1 | Gated array select |
| mem_we_o | output | 1 | Gated array write strobe |
| dq_oe_o | output | 1 | Data bus drive enable |
| wprot_o | output | 1 | Array is write-protected and deselected |
| bat_sel_o | output | 1 | Array supply taken from the battery |

## Verification
The bench builds the block with CLK_NS=8, REC_NS=160 and LAG_NS=40. This gives a 20-cycle recovery and a 5-cycle collapse lag in place of the 250 000 and 25 000 cycles of the defaults. With these values, full recoveries, a recovery restarted by a one-cycle glitch, and both the lagged and the immediate lockout paths all fit in a few hundred cycles. A behavioural model in the bench predicts every output on every cycle, through reset, the strobe modes, inconsistent flag combinations and collapses into battery operation.

// File: rtl/sag_pkg.sv
package sag_pkg;

  typedef enum logic [1:0] {
    LV_GOOD = 2'd0,
    LV_WIN  = 2'd1,
    LV_LOW  = 2'd2,
    LV_BATT = 2'd3
  } sag_lvl_e;

  typedef enum logic [1:0] {
    ST_PROT = 2'd0,
    ST_RUN  = 2'd1,
    ST_LAG  = 2'd2
  } sag_st_e;

  typedef struct packed {
    logic hi;
    logic lo;
    logic bat;
  } sag_flags_t;

  // round a duration up to whole clock cycles
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  // monotonic reading of the three comparator flags: a flag only counts
  // when every lower level is also present
  function automatic sag_lvl_e classify(input sag_flags_t f);
    logic bat_ok, lo_ok, hi_ok;
    bat_ok = f.bat;
    lo_ok  = f.lo & bat_ok;
    hi_ok  = f.hi & lo_ok;
    if (!bat_ok)     return LV_BATT;
    else if (!lo_ok) return LV_LOW;
    else if (!hi_ok) return LV_WIN;
    else             return LV_GOOD;
  endfunction

  function automatic logic is_collapse(input sag_lvl_e l);
    return (l == LV_LOW) || (l == LV_BATT);
  endfunction

endpackage

// File: rtl/sag_sync.sv
module sag_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic st1, st2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= 1'b0;
        st2 <= 1'b0;
      end else begin
        st1 <= d[b];
        st2 <= st1;
      end
    end
    assign q[b] = st2;
  end

endmodule

// File: rtl/sag_timer.sv
module sag_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic done
);

  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end = (cnt == CW'(LIMIT - 1));
  assign done   = run && !clr && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (run) begin
      if (at_end)        cnt <= '0;
      else               cnt <= cnt + 1'b1;
    end
  end

  // R6: a clear always restarts the count from zero
  p_clear_restarts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R6: the count never passes its limit
  p_count_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT - 1));

endmodule

// File: rtl/sag_fsm.sv
module sag_fsm
  import sag_pkg::*;
#(
  parameter int unsigned REC_CYC = 250000,
  parameter int unsigned LAG_CYC = 25000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  sag_lvl_e lvl,
  output logic     prot,
  output logic     lagging
);

  sag_st_e st, st_n;
  logic    rec_done, lag_done;
  logic    good_now, collapse_now;

  assign good_now     = (lvl == LV_GOOD);
  assign collapse_now = is_collapse(lvl);

  // recovery hold-off: runs only while protected at the healthy level
  sag_timer #(.LIMIT(REC_CYC)) u_rec (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   ((st != ST_PROT) || !good_now),
    .run   (st == ST_PROT),
    .done  (rec_done)
  );

  if (LAG_CYC > 0) begin : g_lag
    sag_timer #(.LIMIT(LAG_CYC)) u_lag (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st != ST_LAG),
      .run   (st == ST_LAG),
      .done  (lag_done)
    );
  end else begin : g_nolag
    assign lag_done = 1'b1;
  end

  always_comb begin
    st_n = st;
    unique case (st)
      ST_RUN: begin
        if (lvl == LV_WIN)    st_n = ST_PROT;
        else if (collapse_now) st_n = (LAG_CYC == 0) ? ST_PROT : ST_LAG;
      end
      ST_LAG: begin
        if (lag_done)         st_n = ST_PROT;
      end
      default: begin
        if (rec_done)         st_n = ST_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_PROT;
    else        st <= st_n;
  end

  assign prot    = (st == ST_PROT);
  assign lagging = (st == ST_LAG);

  // R4: a window level while running locks out at the next edge
  p_window_trips_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && lvl == LV_WIN) |=> prot);

  // R5: skipping the window never keeps the block in plain running mode
  p_collapse_leaves_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && collapse_now) |=> (st != ST_RUN));

  // R5: the lag state only ever ends in protection
  p_lag_ends_protected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LAG) |=> (st == ST_LAG || st == ST_PROT));

  // R6: release only follows a healthy cycle
  p_release_after_good_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot) |-> $past(good_now));

endmodule

// File: rtl/sag_gate.sv
module sag_gate (
  input  logic prot,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic sel,
  output logic wr,
  output logic drive
);

  logic enabled;

  assign enabled = !prot && !ce_n;
  assign sel     = enabled;
  assign wr      = enabled && !we_n;
  assign drive   = enabled && we_n && !oe_n;

endmodule

// File: rtl/supply_access_guard.sv
module supply_access_guard
  import sag_pkg::*;
#(
  parameter int unsigned CLK_NS = 8,
  parameter int unsigned REC_NS = 2000000,
  parameter int unsigned LAG_NS = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_hi_i,
  input  logic vcc_lo_i,
  input  logic vcc_bat_i,
  input  logic ce_n_i,
  input  logic oe_n_i,
  input  logic we_n_i,
  output logic access_o,
  output logic mem_we_o,
  output logic dq_oe_o,
  output logic wprot_o,
  output logic bat_sel_o
);

  localparam int unsigned REC_RAW = ns_to_cyc(REC_NS, CLK_NS);
  localparam int unsigned REC_CYC = (REC_RAW == 0) ? 1 : REC_RAW;
  localparam int unsigned LAG_CYC = ns_to_cyc(LAG_NS, CLK_NS);

  sag_flags_t flags_raw, flags_sync;
  sag_lvl_e   lvl;
  logic       prot, lagging;

  assign flags_raw = '{hi: vcc_hi_i, lo: vcc_lo_i, bat: vcc_bat_i};

  sag_sync #(.W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (flags_raw),
    .q     (flags_sync)
  );

  assign lvl = classify(flags_sync);

  sag_fsm #(.REC_CYC(REC_CYC), .LAG_CYC(LAG_CYC)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (lvl),
    .prot    (prot),
    .lagging (lagging)
  );

  sag_gate u_gate (
    .prot  (prot),
    .ce_n  (ce_n_i),
    .oe_n  (oe_n_i),
    .we_n  (we_n_i),
    .sel   (access_o),
    .wr    (mem_we_o),
    .drive (dq_oe_o)
  );

  assign wprot_o   = prot;
  assign bat_sel_o = (lvl == LV_BATT);

  // R9: a protected array sees no select, write or drive
  p_prot_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wprot_o |-> (!access_o && !mem_we_o && !dq_oe_o));

  // R8: the data bus is never driven during a write
  p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && dq_oe_o));

  // R10: the cycle protection rises carries no write strobe
  p_write_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wprot_o) |-> !mem_we_o);

  // R7: on battery the block is never in plain running mode for long
  p_batt_not_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_sel_o && !wprot_o && !lagging) |=> (wprot_o || lagging));

endmodule

// File: tb/test_supply_access_guard.sv
module test_supply_access_guard;

  localparam int CLK_NS = 8;
  localparam int M_REC  = 20;  // 160 ns / 8 ns
  localparam int M_LAG  = 5;   // 40 ns / 8 ns

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi = 1'b1, lo = 1'b1, bat = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic access_o, mem_we_o, dq_oe_o, wprot_o, bat_sel_o;

  int compared = 0;
  int mismatched = 0;
  bit running = 1'b0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  supply_access_guard #(.CLK_NS(CLK_NS), .REC_NS(160), .LAG_NS(40)) i_supply_access_guard (
    .clk (clk), .rst_n (rst_n),
    .vcc_hi_i (hi), .vcc_lo_i (lo), .vcc_bat_i (bat),
    .ce_n_i (ce_n), .oe_n_i (oe_n), .we_n_i (we_n),
    .access_o (access_o), .mem_we_o (mem_we_o), .dq_oe_o (dq_oe_o),
    .wprot_o (wprot_o), .bat_sel_o (bat_sel_o)
  );

  // ---------------- reference model ----------------
  // mode: 0 locked, 1 running, 2 lagging after a collapse
  int mode = 0;
  int good_run = 0;
  int lag_left = 0;
  logic [2:0] hist[$];
  logic [2:0] syn = 3'b000;   // {hi, lo, bat} as seen after two stages

  function automatic int level_of(input logic [2:0] f);
    if (f[0] == 1'b0) return 3;           // battery
    if (f[1] == 1'b0) return 2;           // below lower
    if (f[2] == 1'b0) return 1;           // window
    return 0;                             // healthy
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mode = 0; good_run = 0; lag_left = 0;
      hist.delete();
      syn = 3'b000;
    end else begin
      int lv;
      lv = level_of(syn);
      if (mode == 1) begin
        if (lv == 1) mode = 0;
        else if (lv >= 2) begin
          if (M_LAG == 0) mode = 0;
          else begin mode = 2; lag_left = M_LAG; end
        end
        good_run = 0;
      end else if (mode == 2) begin
        lag_left--;
        if (lag_left == 0) mode = 0;
        good_run = 0;
      end else begin
        if (lv == 0) begin
          good_run++;
          if (good_run == M_REC) begin mode = 1; good_run = 0; end
        end else good_run = 0;
      end
      hist.push_back({hi, lo, bat});
      if (hist.size() > 2) void'(hist.pop_front());
      syn = (hist.size() == 2) ? hist[0] : 3'b000;
    end
  end

  task automatic cmp(input string tag, input string nm, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      logic e_prot, e_acc, e_we, e_oe, e_bat;
      e_prot = (mode == 0);
      e_bat  = !syn[0];
      e_acc  = !e_prot && !ce_n;
      e_we   = e_acc && !we_n;
      e_oe   = e_acc && we_n && !oe_n;
      cmp("R1 R3 R4 R5 R6", "wprot_o", wprot_o, e_prot);
      cmp("R2 R7", "bat_sel_o", bat_sel_o, e_bat);
      cmp("R8 R9", "access_o", access_o, e_acc);
      cmp("R8 R10", "mem_we_o", mem_we_o, e_we);
      cmp("R8 R9", "dq_oe_o", dq_oe_o, e_oe);
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    running = 1'b1;
    tick(3);                       // R1: reset state observed during reset
    rst_n = 1'b1;
    // R9: strobes ignored while the recovery hold-off runs
    ce_n = 0; oe_n = 0; we_n = 1; tick(10);
    we_n = 0; tick(5);
    we_n = 1; ce_n = 1; tick(15);  // R6: release after 20 healthy cycles
    // R8: mode table
    ce_n = 0; we_n = 0; tick(3);
    we_n = 1; oe_n = 0; tick(3);
    oe_n = 1; tick(2);
    ce_n = 1; oe_n = 0; tick(2);
    oe_n = 1;
    // R4 R10: window entry during a write
    ce_n = 0; we_n = 0; tick(2);
    hi = 0; tick(4);
    hi = 1; tick(8);
    // R6: one-cycle glitch restarts recovery
    lo = 0; tick(1);
    lo = 1; tick(26);
    we_n = 1; ce_n = 1; tick(2);
    // R3 R5: inconsistent flags (hi without lo) read as collapse, lagged lockout
    ce_n = 0; oe_n = 0;
    lo = 0; tick(10);
    lo = 1; tick(30);
    // R3 R7: hi and lo set but switchover flag clear reads as battery
    bat = 0; tick(10);
    bat = 1; tick(30);
    // R5 R7 R2: full fast collapse during a read, then staged return
    hi = 0; lo = 0; bat = 0; tick(12);
    bat = 1; tick(4);
    lo = 1; tick(4);
    hi = 1; tick(30);
    // R4: slow fall through the window, no lag
    hi = 0; tick(3);
    lo = 0; tick(3);
    bat = 0; tick(3);
    bat = 1; lo = 1; hi = 1; tick(30);
    oe_n = 1; ce_n = 1; tick(3);
    finished = 1'b1;
    running = 1'b0;
    summary();
  end

endmodule